// File: doc/BRIEF.md
# Set-Associative Data Address Translator

This block maps data virtual addresses onto physical addresses through a small set-associative translation buffer. Each way of each set holds two 32-bit words. The match word carries the virtual page tag, a valid bit and a small usage-age field. The translate word carries the physical page number, a cache-inhibit bit and four permission bits, one for each pairing of read or write with user or supervisor mode. Software loads and inspects these words through a simple register-style port addressed by way and set.

A lookup presents a virtual address, a write flag, a supervisor flag and a probe flag. One cycle later the block returns the physical address, a cache-inhibit flag, and either a miss or a page-fault indication, together with the virtual address that caused it. When translation is switched off, or the unit is marked absent, addresses pass through unchanged. A probe lookup answers the same question without touching the usage ages and without raising either exception. The block does not walk page tables and does not refill entries itself.

Top module: `dtlb_xlate`

## Requirements
- R1: When `mmu_en` or `mmu_present` is low, a lookup returns `rsp_paddr` equal to the virtual address. `rsp_ci` equals virtual address bit 31, which makes it high exactly at or above 0x80000000. `rsp_miss` and `rsp_fault` stay low.
- R2: The set is chosen by the address bits directly above the page offset, masked to `NSETS-1`. The tag compare uses only the bits at and above position log2(`PAGE_BYTES`*`NSETS`), so offset bits and set bits take no part in it.
- R3: A way hits only when bit 0 (valid) of its match word is set and its tag bits equal those of the request. When more than one way hits, the lowest-numbered way is used.
- R4: On a permitted hit, `rsp_paddr` is the translate word with its offset bits cleared, ORed with the offset bits of the virtual address. `rsp_ci` is bit 0 of the translate word.
- R5: The translate word's permission bits are user-read at bit 1, user-write at bit 2, supervisor-read at bit 3 and supervisor-write at bit 4. The bit checked is chosen by `req_super` and `req_write`. A hit whose bit is clear raises `rsp_fault`, with `rsp_paddr` and `rsp_ci` at 0 and `rsp_vaddr` carrying the faulting address.
- R6: A lookup that hits no way raises `rsp_miss`, with `rsp_paddr` at 0 and `rsp_vaddr` carrying the address. Entries are not refilled.
- R7: The age field occupies bits 7:6 of the match word. On a non-probe hit, every way of the selected set that has a nonzero age is decremented by one. The hit way's age is then ORed with (`NSETS-1`) truncated to two bits.
- R8: A probe lookup leaves every age unchanged and never raises `rsp_miss` or `rsp_fault`. It returns 0 on a miss or a permission failure, and the untranslated address in pass-through mode.
- R9: Reset clears every match word and every translate word, including all valid bits and ages. `cfg_rdata` shows, combinationally, the word chosen by `cfg_way`, `cfg_set` and `cfg_tr` (1 selects the translate word, 0 the match word).
- R10: A lookup can be accepted every cycle. Its result appears with `rsp_valid` high exactly one clock later, and `rsp_valid` is low in the cycle after no lookup.
- R11: An entry write (`cfg_we`) in the same cycle as a lookup of the same set takes effect after that lookup. The lookup sees the old entry, and the written value replaces any age update made by that lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mmu_en | input | 1 | Translation enable |
| mmu_present | input | 1 | Unit-present flag |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Lookup is a write access |
| req_super | input | 1 | Lookup is in supervisor mode |
| req_probe | input | 1 | Side-effect-free probe lookup |
| cfg_we | input | 1 | Entry write strobe |
| cfg_tr | input | 1 | 1 selects translate word, 0 selects match word |
| cfg_way | input | WAY_W | Entry way |
| cfg_set | input | SET_W | Entry set |
| cfg_wdata | input | 32 | Entry write data |
| cfg_rdata | output | 32 | Selected entry word |
| rsp_valid | output | 1 | Result valid |
| rsp_paddr | output | 32 | Physical address |
| rsp_ci | output | 1 | Cache inhibit |
| rsp_miss | output | 1 | Translation miss |
| rsp_fault | output | 1 | Page fault |
| rsp_vaddr | output | 32 | Virtual address of the result |

## Verification
Two things can happen to one entry in the same clock. A lookup can hit it and age it, while a software write replaces it. The bench provokes this by driving `cfg_we` to a translate word, and separately to a match word, in the same cycle as a hitting lookup of that set. The result must carry the old translation, the next lookup must see the new one, and the read-back word must equal the written value rather than the aged one.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
    localparam int VA_W    = 32;
    localparam int AGE_LSB = 6;
    localparam int AGE_W   = 2;
    localparam int B_VALID = 0;
    localparam int B_CI    = 0;
    localparam int B_UR    = 1;
    localparam int B_UW    = 2;
    localparam int B_SR    = 3;
    localparam int B_SW    = 4;

    typedef struct packed {
        logic            valid;
        logic [VA_W-1:0] paddr;
        logic            ci;
        logic            miss;
        logic            fault;
        logic [VA_W-1:0] vaddr;
    } rsp_t;
endpackage

// File: rtl/dtlb_lookup.sv
module dtlb_lookup
    import dtlb_pkg::*;
#(
    parameter int NWAYS   = 1,
    parameter int OFF_W   = 13,
    parameter int CMP_LSB = 13
) (
    input  logic [NWAYS-1:0][VA_W-1:0] mrow,
    input  logic [NWAYS-1:0][VA_W-1:0] trow,
    input  logic [VA_W-1:0]            vaddr,
    input  logic                       wr,
    input  logic                       sup,
    output logic                       hit,
    output logic [NWAYS-1:0]           hit_oh,
    output logic [VA_W-1:0]            paddr,
    output logic                       ci,
    output logic                       perm_ok
);
    localparam logic [VA_W-1:0] TAG_MASK = {VA_W{1'b1}} << CMP_LSB;
    localparam logic [VA_W-1:0] OFF_MASK = ~({VA_W{1'b1}} << OFF_W);

    logic [NWAYS-1:0] way_match;
    logic [VA_W-1:0]  tsel;

    for (genvar w = 0; w < NWAYS; w++) begin : g_cmp
        assign way_match[w] = mrow[w][B_VALID] &&
                              ((mrow[w] & TAG_MASK) == (vaddr & TAG_MASK));
    end

    // lowest matching way wins
    always_comb begin
        tsel   = '0;
        hit_oh = '0;
        for (int w = NWAYS - 1; w >= 0; w--) begin
            if (way_match[w]) begin
                tsel      = trow[w];
                hit_oh    = '0;
                hit_oh[w] = 1'b1;
            end
        end
    end

    assign hit     = |way_match;
    assign paddr   = (tsel & ~OFF_MASK) | (vaddr & OFF_MASK);
    assign ci      = tsel[B_CI];
    assign perm_ok = sup ? (wr ? tsel[B_SW] : tsel[B_SR])
                         : (wr ? tsel[B_UW] : tsel[B_UR]);
endmodule

// File: rtl/dtlb_age.sv
module dtlb_age
    import dtlb_pkg::*;
#(
    parameter int NWAYS = 1,
    parameter int NSETS = 1
) (
    input  logic [NWAYS-1:0][VA_W-1:0] mrow,
    input  logic [NWAYS-1:0]           hit_oh,
    output logic [NWAYS-1:0][VA_W-1:0] mrow_nx
);
    localparam logic [AGE_W-1:0] RELOAD = AGE_W'(NSETS - 1);

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        logic [AGE_W-1:0] age_cur;
        logic [AGE_W-1:0] age_dec;
        logic [AGE_W-1:0] age_new;
        always_comb begin
            age_cur = mrow[w][AGE_LSB +: AGE_W];
            age_dec = (age_cur != '0) ? age_cur - 1'b1 : age_cur;
            age_new = hit_oh[w] ? (age_dec | RELOAD) : age_dec;
            mrow_nx[w] = mrow[w];
            mrow_nx[w][AGE_LSB +: AGE_W] = age_new;
        end
    end
endmodule

// File: rtl/dtlb_xlate.sv
module dtlb_xlate
    import dtlb_pkg::*;
#(
    parameter int NWAYS      = 1,
    parameter int NSETS      = 1,
    parameter int PAGE_BYTES = 8192,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int IDX_BITS  = $clog2(NSETS),
    localparam int SET_W     = (IDX_BITS > 0) ? IDX_BITS : 1,
    localparam int WAY_W     = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mmu_en,
    input  logic             mmu_present,
    input  logic             req_valid,
    input  logic [31:0]      req_vaddr,
    input  logic             req_write,
    input  logic             req_super,
    input  logic             req_probe,
    input  logic             cfg_we,
    input  logic             cfg_tr,
    input  logic [WAY_W-1:0] cfg_way,
    input  logic [SET_W-1:0] cfg_set,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    output logic             rsp_valid,
    output logic [31:0]      rsp_paddr,
    output logic             rsp_ci,
    output logic             rsp_miss,
    output logic             rsp_fault,
    output logic [31:0]      rsp_vaddr
);
    localparam int CMP_LSB = OFF_W + IDX_BITS;
    localparam logic [SET_W-1:0] SET_MASK = SET_W'(NSETS - 1);

    typedef struct packed {
        rsp_t                                     rsp;
        logic [NWAYS-1:0][NSETS-1:0][VA_W-1:0]    mtch;
        logic [NWAYS-1:0][NSETS-1:0][VA_W-1:0]    trn;
    } state_t;

    state_t s_d, s_q;

    logic [SET_W-1:0]            set_idx;
    logic [NWAYS-1:0][VA_W-1:0]  mrow, trow, mrow_aged;
    logic                        lk_hit, lk_ci, lk_ok;
    logic [NWAYS-1:0]            lk_oh;
    logic [VA_W-1:0]             lk_paddr;
    logic                        xlate_on, cfg_in_range;

    assign set_idx = req_vaddr[OFF_W +: SET_W] & SET_MASK;

    for (genvar w = 0; w < NWAYS; w++) begin : g_row
        assign mrow[w] = s_q.mtch[w][set_idx];
        assign trow[w] = s_q.trn[w][set_idx];
    end

    dtlb_lookup #(.NWAYS(NWAYS), .OFF_W(OFF_W), .CMP_LSB(CMP_LSB)) u_lookup (
        .mrow    (mrow),
        .trow    (trow),
        .vaddr   (req_vaddr),
        .wr      (req_write),
        .sup     (req_super),
        .hit     (lk_hit),
        .hit_oh  (lk_oh),
        .paddr   (lk_paddr),
        .ci      (lk_ci),
        .perm_ok (lk_ok)
    );

    dtlb_age #(.NWAYS(NWAYS), .NSETS(NSETS)) u_age (
        .mrow    (mrow),
        .hit_oh  (lk_oh),
        .mrow_nx (mrow_aged)
    );

    assign xlate_on     = mmu_en && mmu_present;
    assign cfg_in_range = (32'(cfg_way) < NWAYS) && (32'(cfg_set) < NSETS);

    always_comb begin
        s_d     = s_q;
        s_d.rsp = '0;
        if (req_valid) begin
            s_d.rsp.valid = 1'b1;
            s_d.rsp.vaddr = req_vaddr;
            if (!xlate_on) begin
                s_d.rsp.paddr = req_vaddr;
                s_d.rsp.ci    = req_vaddr[VA_W-1];
            end else if (lk_hit) begin
                if (lk_ok) begin
                    s_d.rsp.paddr = lk_paddr;
                    s_d.rsp.ci    = lk_ci;
                end else begin
                    s_d.rsp.fault = !req_probe;
                end
                if (!req_probe) begin
                    for (int w = 0; w < NWAYS; w++) begin
                        s_d.mtch[w][set_idx] = mrow_aged[w];
                    end
                end
            end else begin
                s_d.rsp.miss = !req_probe;
            end
        end
        // entry writes land after the lookup's own update
        if (cfg_we && cfg_in_range) begin
            if (cfg_tr) s_d.trn[cfg_way][cfg_set]  = cfg_wdata;
            else        s_d.mtch[cfg_way][cfg_set] = cfg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_in_range) begin
            cfg_rdata = cfg_tr ? s_q.trn[cfg_way][cfg_set] : s_q.mtch[cfg_way][cfg_set];
        end
    end

    assign rsp_valid = s_q.rsp.valid;
    assign rsp_paddr = s_q.rsp.paddr;
    assign rsp_ci    = s_q.rsp.ci;
    assign rsp_miss  = s_q.rsp.miss;
    assign rsp_fault = s_q.rsp.fault;
    assign rsp_vaddr = s_q.rsp.vaddr;
endmodule

// File: rtl/dtlb_checker.sv
module dtlb_checker #(
    parameter int PAGE_BYTES = 8192
) (
    input logic        clk,
    input logic        rst_n,
    input logic        mmu_en,
    input logic        mmu_present,
    input logic        req_valid,
    input logic [31:0] req_vaddr,
    input logic        req_probe,
    input logic        rsp_valid,
    input logic [31:0] rsp_paddr,
    input logic        rsp_ci,
    input logic        rsp_miss,
    input logic        rsp_fault,
    input logic [31:0] rsp_vaddr
);
    localparam int OFF_W = $clog2(PAGE_BYTES);

    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !(mmu_en && mmu_present)) |=>
            (rsp_paddr == $past(req_vaddr)) && (rsp_ci == $past(req_vaddr[31]))
            && !rsp_miss && !rsp_fault);

    p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_miss && rsp_fault));

    p_zero_on_exc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_miss || rsp_fault)) |-> (rsp_paddr == '0) && !rsp_ci);

    p_probe_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_probe) |=> !rsp_miss && !rsp_fault);

    p_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_miss && !rsp_fault && (rsp_paddr != '0)) |->
            (rsp_paddr[OFF_W-1:0] == rsp_vaddr[OFF_W-1:0]));
endmodule

bind dtlb_xlate dtlb_checker #(.PAGE_BYTES(PAGE_BYTES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mmu_en      (mmu_en),
    .mmu_present (mmu_present),
    .req_valid   (req_valid),
    .req_vaddr   (req_vaddr),
    .req_probe   (req_probe),
    .rsp_valid   (rsp_valid),
    .rsp_paddr   (rsp_paddr),
    .rsp_ci      (rsp_ci),
    .rsp_miss    (rsp_miss),
    .rsp_fault   (rsp_fault),
    .rsp_vaddr   (rsp_vaddr)
);

// File: tb/sim_dtlb_xlate.sv
module sim_dtlb_xlate;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 2;
    localparam int NS = 4;
    localparam int PB = 4096;
    localparam logic [31:0] TAGM = 32'hFFFF_C000;
    localparam logic [31:0] OFFM = 32'h0000_0FFF;

    typedef struct packed {
        logic [31:0] paddr;
        logic        ci;
        logic        miss;
        logic        fault;
        logic [31:0] vaddr;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mmu_en = 1'b0, mmu_present = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_super = 1'b0, req_probe = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic cfg_we = 1'b0, cfg_tr = 1'b0;
    logic [0:0] cfg_way = '0;
    logic [1:0] cfg_set = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata, rsp_paddr, rsp_vaddr;
    logic rsp_valid, rsp_ci, rsp_miss, rsp_fault;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    exp_t  eq[$];
    string tq[$];
    logic [31:0] bm [NW][NS];
    logic [31:0] bt [NW][NS];

    always #(CLK_PERIOD/2) clk = ~clk;

    dtlb_xlate #(.NWAYS(NW), .NSETS(NS), .PAGE_BYTES(PB)) u0 (
        .clk(clk), .rst_n(rst_n), .mmu_en(mmu_en), .mmu_present(mmu_present),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
        .req_super(req_super), .req_probe(req_probe),
        .cfg_we(cfg_we), .cfg_tr(cfg_tr), .cfg_way(cfg_way), .cfg_set(cfg_set),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_ci(rsp_ci),
        .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_vaddr(rsp_vaddr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int w = 0; w < NW; w++)
            for (int s = 0; s < NS; s++) begin
                bm[w][s] = '0;
                bt[w][s] = '0;
            end
    endtask

    // one cycle: optional lookup, then optional entry write (R11 ordering)
    task automatic cyc(input bit lv, input logic [31:0] va, input bit wr, input bit sup,
                       input bit prb, input bit we, input bit tr, input int way,
                       input int set, input logic [31:0] wd);
        exp_t e;
        string tag;
        @(negedge clk);
        req_valid = lv; req_vaddr = va; req_write = wr; req_super = sup; req_probe = prb;
        cfg_we = we; cfg_tr = tr; cfg_way = way[0:0]; cfg_set = set[1:0]; cfg_wdata = wd;
        if (lv) begin
            e = '0;
            e.vaddr = va;
            if (!(mmu_en && mmu_present)) begin
                e.paddr = va; e.ci = va[31]; tag = "R1";
            end else begin
                int s, hw;
                s = int'((va >> 12) & 32'd3);   // R2 set index
                hw = -1;
                for (int w = NW - 1; w >= 0; w--)
                    if (bm[w][s][0] && ((bm[w][s] & TAGM) == (va & TAGM))) hw = w;  // R3
                if (hw < 0) begin
                    e.miss = !prb; tag = prb ? "R8" : "R6";
                end else begin
                    logic [31:0] t;
                    bit ok;
                    t = bt[hw][s];
                    ok = sup ? (wr ? t[4] : t[3]) : (wr ? t[2] : t[1]);
                    if (ok) begin
                        e.paddr = (t & ~OFFM) | (va & OFFM); e.ci = t[0];
                        tag = prb ? "R8" : "R4";
                    end else begin
                        e.fault = !prb; tag = prb ? "R8" : "R5";
                    end
                    if (!prb) begin   // R7 aging
                        for (int w = 0; w < NW; w++) begin
                            logic [1:0] a;
                            a = bm[w][s][7:6];
                            if (a != 0) a = a - 1;
                            if (w == hw) a = a | 2'(NS - 1);
                            bm[w][s][7:6] = a;
                        end
                    end
                end
            end
            eq.push_back(e);
            tq.push_back(tag);
        end
        if (we) begin
            if (tr) bt[way][set] = wd;
            else    bm[way][set] = wd;
        end
    endtask

    task automatic look(input logic [31:0] va, input bit wr, input bit sup, input bit prb);
        cyc(1'b1, va, wr, sup, prb, 1'b0, 1'b0, 0, 0, '0);
    endtask

    task automatic wentry(input bit tr, input int way, input int set, input logic [31:0] wd);
        cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, tr, way, set, wd);
    endtask

    task automatic idle();
        cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0, '0);
    endtask

    task automatic readback(input string tag, input bit tr, input int way, input int set);
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
        cfg_tr = tr; cfg_way = way[0:0]; cfg_set = set[1:0];
        #1;
        check(tag, cfg_rdata, tr ? bt[way][set] : bm[way][set]);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (eq.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R10 actual=unexpected response expected=none");
            end else begin
                exp_t e;
                string tag;
                e = eq.pop_front();
                tag = tq.pop_front();
                check(tag, rsp_paddr, e.paddr);
                check(tag, {31'b0, rsp_ci}, {31'b0, e.ci});
                check(tag, {31'b0, rsp_miss}, {31'b0, e.miss});
                check(tag, {31'b0, rsp_fault}, {31'b0, e.fault});
                check(tag, rsp_vaddr, e.vaddr);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R9: reset state, then reset wipes a written entry
        check("R9 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
        wentry(1'b0, 1, 2, 32'hFFFF_FFFF);
        wentry(1'b1, 1, 2, 32'hFFFF_FFFF);
        readback("R9 written", 1'b0, 1, 2);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        model_clear();
        readback("R9 cleared match", 1'b0, 1, 2);
        readback("R9 cleared translate", 1'b1, 1, 2);

        // R1: pass-through in both disable forms
        look(32'h8000_1234, 1'b0, 1'b0, 1'b0);
        look(32'h7FFF_FFFF, 1'b1, 1'b1, 1'b0);
        look(32'h8000_0000, 1'b0, 1'b0, 1'b1);
        mmu_en = 1'b1;
        look(32'hC000_0040, 1'b0, 1'b0, 1'b0);
        idle();

        // load entries: set 1 way0 full perms, set 1 way1 user-read+CI with age 2
        wentry(1'b0, 0, 1, 32'h1234_4001);
        wentry(1'b1, 0, 1, 32'hABCD_E01E);
        wentry(1'b0, 1, 1, 32'h5678_4081);
        wentry(1'b1, 1, 1, 32'h0BEE_F003);
        wentry(1'b0, 0, 2, 32'h1234_4000);     // invalid entry in set 2
        wentry(1'b1, 0, 2, 32'h5555_501E);
        mmu_present = 1'b1;
        look(32'h7000_0000, 1'b0, 1'b0, 1'b0); // R6 empty set 0 miss

        // R4 hits, R2 set selection, R3 valid gating, R5 permissions, R10 back-to-back
        look(32'h1234_5678, 1'b0, 1'b0, 1'b0);
        look(32'h5678_5ABC, 1'b0, 1'b0, 1'b0);
        look(32'h5678_5ABC, 1'b1, 1'b0, 1'b0);
        look(32'h5678_5ABC, 1'b0, 1'b1, 1'b0);
        look(32'h1234_5FFF, 1'b1, 1'b1, 1'b0);
        look(32'h1234_6678, 1'b0, 1'b0, 1'b0);
        look(32'h2234_5678, 1'b0, 1'b0, 1'b0);
        look(32'h1234_4678, 1'b0, 1'b0, 1'b0); // same tag, set 0: miss (R2)
        idle();
        readback("R7 age way0", 1'b0, 0, 1);
        readback("R7 age way1", 1'b0, 1, 1);
        look(32'h5678_5000, 1'b0, 1'b0, 1'b0);
        idle();
        readback("R7 age way0 after way1 hit", 1'b0, 0, 1);
        readback("R7 age way1 after hit", 1'b0, 1, 1);

        // R8 probes: hit, fault, miss, ages untouched
        look(32'h1234_5100, 1'b0, 1'b0, 1'b1);
        look(32'h5678_5100, 1'b1, 1'b0, 1'b1);
        look(32'h9999_9100, 1'b0, 1'b0, 1'b1);
        idle();
        readback("R8 ages untouched way0", 1'b0, 0, 1);
        readback("R8 ages untouched way1", 1'b0, 1, 1);

        // R11: translate write with hitting lookup; match write with hitting lookup
        cyc(1'b1, 32'h1234_5010, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 0, 1, 32'h1111_101E);
        look(32'h1234_5010, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 32'h5678_5020, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1, 1, 32'h5678_4001);
        idle();
        readback("R11 match write wins over aging", 1'b0, 1, 1);
        readback("R11 neighbour aged", 1'b0, 0, 1);
        look(32'h5678_5020, 1'b0, 1'b1, 1'b0);

        // R10 streaming lookups across sets
        for (int i = 0; i < 12; i++)
            look(32'h1234_4000 + 32'(i) * 32'h0000_1004, i[0], i[1], 1'b0);
        idle();
        idle();
        check("R10 queue drained", 32'(eq.size()), 32'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule